// File: doc/BRIEF.md
# Masked Ternary Entry Write Path

This block sits in front of a ternary match array and decides what gets written into it, and where. A write takes its entry address from the command bus or from a register that holds the most recent search hit address. It takes its data from the command bus, from a register that holds the last search key that missed, or from a register that holds an entry copied out of the array. A per-bit keep mask lets a write change only part of an entry. The block also offers a dual-mat write that stores one word in both halves of the array at the same offset, a delete that returns an entry to its empty pattern, and a three-step move that relocates an entry.

Each ternary cell is two stored bits: bit 2i is the even bit and bit 2i+1 is the odd bit of cell i. The empty cell is even=0, odd=1, so an empty 8-cell entry reads 16'hAAAA. The array itself is a register model. The search logic is outside this block and reports its results through the `srch_*` inputs.

Top module: `cwr_write_path`

## Requirements
- R1: After reset every entry reads as all-empty cells (16'hAAAA at default size), busy and err are low, and rd_valid and idx_valid are low.
- R2: A write (cmd_op 1) with cmd_addr_sel=0, cmd_data_sel=0 and cmd_dual=0 stores cmd_data at cmd_addr only. The mat is chosen by the top address bit, and the other mat is not touched.
- R3: cmd_op 5 loads the keep mask from cmd_data and leaves the array unchanged. During a write, a bit whose mask bit is 1 keeps its former stored value, and a bit whose mask bit is 0 takes the new data.
- R4: A search result with srch_valid=1 and srch_hit=1 loads srch_addr into the address register. A write with cmd_addr_sel=1 uses that register as its address.
- R5: A write with cmd_addr_sel=1 raises idx_valid for exactly one cycle, on the cycle after it is accepted, with idx_addr equal to the address used.
- R6: A search result with srch_valid=1 and srch_hit=0 loads srch_key into the miss-key register, and a hit does not change it. A write with cmd_data_sel=1 stores that key. cmd_data_sel=2 selects the copied-entry register, and 0 or 3 selects cmd_data.
- R7: A write with cmd_dual=1 ignores the top address bit. It stores the masked word in both mats at the offset given by the remaining bits, and both mats use the same keep mask.
- R8: A delete (cmd_op 2) sets every cell of entry cmd_addr to empty, whatever the keep mask holds.
- R9: A move (cmd_op 3) copies entry cmd_addr into the copied-entry register, then empties cmd_addr, then writes the copy to cmd_dst without masking. The copy remains available to later writes with cmd_data_sel=2.
- R10: busy is high for the two cycles after a move is accepted. A command presented while busy is high has no effect and raises err for one cycle on the following cycle.
- R11: A read (cmd_op 4) gives rd_valid for one cycle, with rd_data equal to entry cmd_addr, on the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 0 nop, 1 write, 2 delete, 3 move, 4 read, 5 load mask |
| cmd_addr | input | ADDR_W | Entry address (move source) |
| cmd_dst | input | ADDR_W | Move destination |
| cmd_data | input | 2*CELLS | Write data or mask value |
| cmd_addr_sel | input | 1 | Write address source: 0 bus, 1 hit register |
| cmd_data_sel | input | 2 | Write data source: 0/3 bus, 1 miss key, 2 copied entry |
| cmd_dual | input | 1 | Write both mats at the same offset |
| srch_valid | input | 1 | Search result present |
| srch_hit | input | 1 | Search result was a hit |
| srch_addr | input | ADDR_W | Hit address |
| srch_key | input | 2*CELLS | Key that was searched |
| busy | output | 1 | Move sequence in progress |
| err | output | 1 | Command rejected while busy |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 2*CELLS | Read entry |
| idx_valid | output | 1 | Register-sourced write address reported |
| idx_addr | output | ADDR_W | Address used by that write |

## Verification
A wrong source select or a stale hit or miss register shows up at the next read of the written entry. It also shows on idx_addr in the cycle right after the write. A wrong mask merge or a dual write that leaks into the wrong mat is caught by reading both mats at the affected offset with a mask partly set. A move sequencer that takes the wrong number of steps, or lets a command through, appears on busy and err within three cycles of the move. The entry that was overwritten by mistake, or the source that was not emptied, appears at the next read.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_WRITE  = 3'd1,
        OP_DELETE = 3'd2,
        OP_MOVE   = 3'd3,
        OP_READ   = 3'd4,
        OP_MASK   = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_CLEAR = 2'd1,
        MV_PLACE = 2'd2
    } mv_e;

    localparam logic [1:0] DSEL_BUS  = 2'd0;
    localparam logic [1:0] DSEL_MISS = 2'd1;
    localparam logic [1:0] DSEL_COPY = 2'd2;

    // one ternary cell: {odd, even}; empty is even=0, odd=1
    localparam logic [1:0] CELL_EMPTY = 2'b10;
endpackage

// File: rtl/cwr_src_sel.sv
module cwr_src_sel #(
    parameter int ADDR_W = 4,
    parameter int EW     = 16
) (
    input  logic              addr_sel,
    input  logic [1:0]        data_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [EW-1:0]     bus_data,
    input  logic [ADDR_W-1:0] hit_addr,
    input  logic [EW-1:0]     miss_key,
    input  logic [EW-1:0]     copy_word,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [EW-1:0]     wr_data
);
    import cwr_pkg::*;

    always_comb begin
        wr_addr = addr_sel ? hit_addr : bus_addr;
        case (data_sel)
            DSEL_MISS: wr_data = miss_key;
            DSEL_COPY: wr_data = copy_word;
            default:   wr_data = bus_data;
        endcase
    end
endmodule

// File: rtl/cwr_mask_merge.sv
module cwr_mask_merge #(
    parameter int EW = 16
) (
    input  logic [EW-1:0] old_word,
    input  logic [EW-1:0] new_word,
    input  logic [EW-1:0] keep_mask,
    output logic [EW-1:0] merged
);
    // mask bit 1 keeps what is stored, 0 takes the new bit
    assign merged = (old_word & keep_mask) | (new_word & ~keep_mask);
endmodule

// File: rtl/cwr_write_path.sv
module cwr_write_path #(
    parameter int ADDR_W = 4,
    parameter int CELLS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [2:0]           cmd_op,
    input  logic [ADDR_W-1:0]    cmd_addr,
    input  logic [ADDR_W-1:0]    cmd_dst,
    input  logic [2*CELLS-1:0]   cmd_data,
    input  logic                 cmd_addr_sel,
    input  logic [1:0]           cmd_data_sel,
    input  logic                 cmd_dual,
    input  logic                 srch_valid,
    input  logic                 srch_hit,
    input  logic [ADDR_W-1:0]    srch_addr,
    input  logic [2*CELLS-1:0]   srch_key,
    output logic                 busy,
    output logic                 err,
    output logic                 rd_valid,
    output logic [2*CELLS-1:0]   rd_data,
    output logic                 idx_valid,
    output logic [ADDR_W-1:0]    idx_addr
);
    import cwr_pkg::*;

    localparam int EW      = 2 * CELLS;
    localparam int ENTRIES = 1 << ADDR_W;
    localparam int OFF_W   = ADDR_W - 1;
    localparam int NMAT    = 2;
    localparam logic [EW-1:0] EMPTY_WORD = {CELLS{CELL_EMPTY}};

    typedef struct packed {
        logic [ENTRIES-1:0][EW-1:0] mem;
        logic [EW-1:0]              copy;
        logic [EW-1:0]              miss;
        logic [EW-1:0]              wmask;
        logic [ADDR_W-1:0]          hit;
        logic [ADDR_W-1:0]          mv_src;
        logic [ADDR_W-1:0]          mv_dst;
        mv_e                        mv;
        logic                       rd_valid;
        logic [EW-1:0]              rd_data;
        logic                       idx_valid;
        logic [ADDR_W-1:0]          idx_addr;
        logic                       err;
    } state_t;

    state_t st_d, st_q;

    logic [ADDR_W-1:0] wr_addr;
    logic [EW-1:0]     wr_data;
    logic [ADDR_W-1:0] tgt_addr [NMAT];
    logic [EW-1:0]     merged   [NMAT];
    logic              accept;

    cwr_src_sel #(.ADDR_W(ADDR_W), .EW(EW)) u_src (
        .addr_sel  (cmd_addr_sel),
        .data_sel  (cmd_data_sel),
        .bus_addr  (cmd_addr),
        .bus_data  (cmd_data),
        .hit_addr  (st_q.hit),
        .miss_key  (st_q.miss),
        .copy_word (st_q.copy),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    // one merge per mat: the entry at the write offset in that mat
    for (genvar m = 0; m < NMAT; m++) begin : g_mat
        localparam logic MAT_BIT = 1'(m);
        assign tgt_addr[m] = {MAT_BIT, wr_addr[OFF_W-1:0]};
        cwr_mask_merge #(.EW(EW)) u_merge (
            .old_word  (st_q.mem[tgt_addr[m]]),
            .new_word  (wr_data),
            .keep_mask (st_q.wmask),
            .merged    (merged[m])
        );
    end

    assign busy   = (st_q.mv != MV_IDLE);
    assign accept = cmd_valid && !busy;

    always_comb begin
        st_d           = st_q;
        st_d.rd_valid  = 1'b0;
        st_d.idx_valid = 1'b0;
        st_d.err       = cmd_valid && busy;

        if (srch_valid) begin
            if (srch_hit) st_d.hit  = srch_addr;
            else          st_d.miss = srch_key;
        end

        case (st_q.mv)
            MV_CLEAR: begin
                st_d.mem[st_q.mv_src] = EMPTY_WORD;
                st_d.mv               = MV_PLACE;
            end
            MV_PLACE: begin
                st_d.mem[st_q.mv_dst] = st_q.copy;
                st_d.mv               = MV_IDLE;
            end
            default: ;
        endcase

        if (accept) begin
            case (op_e'(cmd_op))
                OP_WRITE: begin
                    if (cmd_dual) begin
                        for (int m = 0; m < NMAT; m++) st_d.mem[tgt_addr[m]] = merged[m];
                    end else begin
                        st_d.mem[wr_addr] = merged[wr_addr[ADDR_W-1]];
                    end
                    if (cmd_addr_sel) begin
                        st_d.idx_valid = 1'b1;
                        st_d.idx_addr  = wr_addr;
                    end
                end
                OP_DELETE: st_d.mem[cmd_addr] = EMPTY_WORD;
                OP_MOVE: begin
                    st_d.copy   = st_q.mem[cmd_addr];
                    st_d.mv_src = cmd_addr;
                    st_d.mv_dst = cmd_dst;
                    st_d.mv     = MV_CLEAR;
                end
                OP_READ: begin
                    st_d.rd_valid = 1'b1;
                    st_d.rd_data  = st_q.mem[cmd_addr];
                end
                OP_MASK: st_d.wmask = cmd_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.mem <= {ENTRIES{EMPTY_WORD}};
        end else begin
            st_q <= st_d;
        end
    end

    assign err       = st_q.err;
    assign rd_valid  = st_q.rd_valid;
    assign rd_data   = st_q.rd_data;
    assign idx_valid = st_q.idx_valid;
    assign idx_addr  = st_q.idx_addr;
endmodule

// File: rtl/cwr_write_path_chk.sv
module cwr_write_path_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [2:0]        cmd_op,
    input logic              cmd_addr_sel,
    input logic              busy,
    input logic              err,
    input logic              rd_valid,
    input logic              idx_valid,
    input logic [ADDR_W-1:0] idx_addr
);
    import cwr_pkg::*;

    logic take;
    assign take = cmd_valid && !busy;

    a_r10_busy_after_move: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_MOVE) |=> busy);

    a_r10_busy_two_cycles: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |=> !busy);

    a_r10_busy_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |=> busy);

    a_r10_err_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> err);

    a_r10_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && busy) |=> !err);

    a_r5_idx_on_hit_write: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_WRITE && cmd_addr_sel) |=> idx_valid);

    a_r5_idx_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && cmd_op == OP_WRITE && cmd_addr_sel) |=> !idx_valid);

    a_r5_idx_addr_stable_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!(take && cmd_op == OP_WRITE && cmd_addr_sel)) |=> $stable(idx_addr));

    a_r11_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == OP_READ) |=> rd_valid);

    a_r11_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && cmd_op == OP_READ) |=> !rd_valid);
endmodule

bind cwr_write_path cwr_write_path_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr_sel (cmd_addr_sel),
    .busy         (busy),
    .err          (err),
    .rd_valid     (rd_valid),
    .idx_valid    (idx_valid),
    .idx_addr     (idx_addr)
);

// File: tb/cwr_write_path_test.sv
`timescale 1ns/1ps
module cwr_write_path_test;
    localparam int AW = 4;
    localparam int EW = 16;
    localparam logic [2:0] NOP = 3'd0, WR = 3'd1, DEL = 3'd2, MOV = 3'd3, RD = 3'd4, MSK = 3'd5;
    localparam logic [15:0] EMPTY = 16'hAAAA;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0, cmd_dst = '0;
    logic [EW-1:0] cmd_data = '0;
    logic cmd_addr_sel = 1'b0;
    logic [1:0] cmd_data_sel = '0;
    logic cmd_dual = 1'b0;
    logic srch_valid = 1'b0, srch_hit = 1'b0;
    logic [AW-1:0] srch_addr = '0;
    logic [EW-1:0] srch_key = '0;
    logic busy, err, rd_valid, idx_valid;
    logic [EW-1:0] rd_data;
    logic [AW-1:0] idx_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cwr_write_path #(.ADDR_W(AW), .CELLS(8)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_dst(cmd_dst), .cmd_data(cmd_data),
        .cmd_addr_sel(cmd_addr_sel), .cmd_data_sel(cmd_data_sel), .cmd_dual(cmd_dual),
        .srch_valid(srch_valid), .srch_hit(srch_hit), .srch_addr(srch_addr), .srch_key(srch_key),
        .busy(busy), .err(err), .rd_valid(rd_valid), .rd_data(rd_data),
        .idx_valid(idx_valid), .idx_addr(idx_addr)
    );

    typedef struct packed {
        logic [2:0]  op;
        logic [3:0]  addr;
        logic [15:0] data;
        logic        dual;
        logic [3:0]  chk;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{WR,  4'd3,  16'h1234, 1'b0, 4'd3,  16'h1234},
        '{MSK, 4'd0,  16'h00FF, 1'b0, 4'd3,  16'h1234},
        '{WR,  4'd3,  16'hABCD, 1'b0, 4'd3,  16'hAB34},
        '{WR,  4'd5,  16'h5A5A, 1'b1, 4'd13, 16'h5AAA},
        '{NOP, 4'd0,  16'h0000, 1'b0, 4'd5,  16'h5AAA},
        '{MSK, 4'd0,  16'h0000, 1'b0, 4'd3,  16'hAB34},
        '{WR,  4'd14, 16'h0F0F, 1'b1, 4'd6,  16'h0F0F},
        '{NOP, 4'd0,  16'h0000, 1'b0, 4'd14, 16'h0F0F},
        '{MSK, 4'd0,  16'hFF00, 1'b0, 4'd3,  16'hAB34},
        '{DEL, 4'd3,  16'h0000, 1'b0, 4'd3,  16'hAAAA},
        '{MSK, 4'd0,  16'h0000, 1'b0, 4'd3,  16'hAAAA},
        '{WR,  4'd9,  16'h4321, 1'b0, 4'd9,  16'h4321},
        '{NOP, 4'd0,  16'h0000, 1'b0, 4'd1,  16'hAAAA}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input logic [3:0] addr, input logic [15:0] data,
                       input logic dual, input logic asel, input logic [1:0] dsel, input logic [3:0] dst);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
        cmd_dual = dual; cmd_addr_sel = asel; cmd_data_sel = dsel; cmd_dst = dst;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = NOP; cmd_dual = 1'b0; cmd_addr_sel = 1'b0; cmd_data_sel = '0;
    endtask

    task automatic rd_check(input logic [3:0] addr, input logic [15:0] exp, input string tag);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = RD; cmd_addr = addr;
        @(negedge clk);
        check(rd_valid === 1'b1 && rd_data === exp, tag, {15'd0, rd_valid, rd_data}, {16'd1, exp});
        cmd_valid = 1'b0; cmd_op = NOP;
    endtask

    task automatic srch(input logic hit, input logic [3:0] addr, input logic [15:0] key);
        @(negedge clk);
        srch_valid = 1'b1; srch_hit = hit; srch_addr = addr; srch_key = key;
        @(negedge clk);
        srch_valid = 1'b0; srch_hit = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(busy === 1'b0 && err === 1'b0, "R1 busy/err after reset", {busy, err}, 0);
        check(rd_valid === 1'b0 && idx_valid === 1'b0, "R1 valids after reset", {rd_valid, idx_valid}, 0);
        for (int a = 0; a < 16; a++) rd_check(4'(a), EMPTY, "R1 empty entry");

        // table: R2 R3 R7 R8 write, mask, dual-mat and delete behaviour
        for (int i = 0; i < NV; i++) begin
            cmd(VECS[i].op, VECS[i].addr, VECS[i].data, VECS[i].dual, 1'b0, 2'd0, 4'd0);
            rd_check(VECS[i].chk, VECS[i].exp, $sformatf("R2 R3 R7 R8 table row %0d", i));
        end

        // R4 R5: hit-address register as write address, index report
        srch(1'b1, 4'd10, 16'h0000);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = WR; cmd_addr = 4'd0; cmd_data = 16'h7777; cmd_addr_sel = 1'b1;
        @(negedge clk);
        check(idx_valid === 1'b1 && idx_addr === 4'd10, "R5 index report", {idx_valid, idx_addr}, {1'b1, 4'd10});
        cmd_valid = 1'b0; cmd_op = NOP; cmd_addr_sel = 1'b0;
        @(negedge clk);
        check(idx_valid === 1'b0, "R5 index pulse width", idx_valid, 0);
        rd_check(4'd10, 16'h7777, "R4 write at hit address");
        rd_check(4'd0, EMPTY, "R4 bus address unused");

        // R6: miss key capture, hit leaves it alone
        srch(1'b0, 4'd0, 16'hC3C3);
        srch(1'b1, 4'd2, 16'h1111);
        cmd(WR, 4'd11, 16'h0000, 1'b0, 1'b0, 2'd1, 4'd0);
        rd_check(4'd11, 16'hC3C3, "R6 miss key written");
        cmd(WR, 4'd15, 16'h2222, 1'b0, 1'b1, 2'd0, 4'd0);
        rd_check(4'd2, 16'h2222, "R4 later hit replaces address");

        // R9 R10: move with a command rejected while busy
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = MOV; cmd_addr = 4'd9; cmd_dst = 4'd4;
        @(negedge clk);
        check(busy === 1'b1, "R10 busy after move", busy, 1);
        check(err === 1'b0, "R10 no err on accepted move", err, 0);
        cmd_op = WR; cmd_addr = 4'd7; cmd_data = 16'hFFFF;
        @(negedge clk);
        check(err === 1'b1, "R10 err on busy command", err, 1);
        check(busy === 1'b1, "R10 busy second cycle", busy, 1);
        cmd_valid = 1'b0; cmd_op = NOP;
        @(negedge clk);
        check(busy === 1'b0 && err === 1'b0, "R10 idle after move", {busy, err}, 0);
        rd_check(4'd9, EMPTY, "R9 source emptied");
        rd_check(4'd4, 16'h4321, "R9 destination holds copy");
        rd_check(4'd7, EMPTY, "R10 rejected write ignored");
        cmd(WR, 4'd12, 16'h0000, 1'b0, 1'b0, 2'd2, 4'd0);
        rd_check(4'd12, 16'h4321, "R9 copy register as data source");

        // R11: read with no command is quiet, read pulse is one cycle
        @(negedge clk);
        check(rd_valid === 1'b0, "R11 rd_valid one cycle", rd_valid, 0);

        // R1: second reset restores empty entries
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_check(4'd4, EMPTY, "R1 empty after reset");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule